// File: doc/BRIEF.md
# SPI Master with Programmable Chip-Select Timing

This block is a single-channel SPI master for clock-phase-0 transfers. The serial clock rests at a selectable level, low or high. The first clock edge of each bit samples the incoming line. The outgoing line changes on the second edge of each bit. Characters run from 4 to 16 bits and are sent most significant bit first. The serial clock comes from the system clock through a fixed divider. One bit time is two half-periods of that divider.

Around each frame the chip select follows three programmable intervals, each counted in whole bit times. A lead interval runs from chip-select assertion to the first clock edge. A trail interval runs from the last clock edge to negation. After negation comes an idle gap that is never shorter than one bit time. The chip-select polarity is selectable.

A host writes a configuration word while the block is idle. It then presents a transmit character with a start pulse. When the frame ends it reads the received character, which is qualified by a one-cycle done strobe. A start that arrives while a frame is in progress is captured together with its character. It is launched as soon as the current gap has fully elapsed.

Top module: `spicsm_master`

Configuration word layout (`cfg_wdata_i`):

| Bits | Meaning |
|------|---------|
| [0] | Chip-select polarity |
| [1] | Clock idle level |
| [5:2] | Length field |
| [9:6] | Lead field |
| [13:10] | Trail field |
| [18:14] | Gap field |

## Requirements
- R1: The chip-select polarity is set by configuration bit [0]. When it is 1, `cs_o` is low while asserted and high while idle. When it is 0, these levels are inverted. After reset, bit [0] is 1 and `cs_o` is high.
- R2: The clock idle level is set by configuration bit [1]: 0 gives low and 1 gives high. `sclk_o` sits at the idle level whenever the chip select is negated.
- R3: The length field in bits [5:2] gives a character of field+1 bits, from 4 to 16. A field value below 3 gives a 4-bit character. Each frame produces exactly that many leading clock edges.
- R4: `mosi_o` carries the character most significant bit first. The first bit is present before the first clock edge. `mosi_o` changes only on trailing edges. MISO is sampled on each leading edge.
- R5: The first leading clock edge follows chip-select assertion by (2*lead+1)*HALF_DIV system cycles. Lead is the field in bits [9:6]. The clock therefore starts in the middle of the first bit time.
- R6: The chip select negates 2*trail*HALF_DIV system cycles after the last trailing clock edge. Trail is the field in bits [13:10].
- R7: Between frames the chip select stays negated for (gap+1)*2*HALF_DIV system cycles when the next frame is already pending. Gap is the field in bits [18:14]. This is never less than one bit time.
- R8: After the last trailing edge, `done_o` pulses for exactly one system cycle. `rx_data_o` holds the received character right-justified, with zeros above it.
- R9: A start while `busy_o` is high captures `tx_data_i`. That frame starts only after the current gap has fully elapsed.
- R10: A configuration write while `busy_o` is high is ignored.
- R11: After reset `busy_o`, `done_o` and `rx_data_o` are zero. `sclk_o` is low and the length is 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 19 | Configuration word |
| tx_data_i | input | 16 | Transmit character, right-justified |
| start_i | input | 1 | Start request pulse |
| busy_o | output | 1 | A frame, its trail or its gap is in progress |
| done_o | output | 1 | One-cycle end-of-frame strobe |
| rx_data_o | output | 16 | Received character, right-justified |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select |

## Verification
The assertions assume two things about the host. It changes the configuration only while the block is idle; the bench writes it only between frames, apart from one deliberate write during a frame to exercise R10. It also treats `miso_i` as stable around each leading clock edge; the bench's slave model changes MISO only on the system-clock falling edge after a trailing serial-clock edge. Start pulses are single cycles. The bench keeps them apart from configuration writes so that a frame never launches in the same cycle as a configuration update.

// File: rtl/spicsm_pkg.sv
package spicsm_pkg;
  localparam int DATA_W = 16;
  localparam int CFG_W  = 19;
  localparam int CNT_W  = 7;
  localparam int BITS_W = 5;

  typedef struct packed {
    logic [4:0] gap;
    logic [3:0] trail;
    logic [3:0] lead;
    logic [3:0] len;
    logic       clk_inv;
    logic       cs_low;
  } spi_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL, ST_GAP
  } seq_state_e;

  localparam spi_cfg_t CFG_RESET = '{gap: 5'd0, trail: 4'd0, lead: 4'd0,
                                     len: 4'd7, clk_inv: 1'b0, cs_low: 1'b1};

  // character length in bits, illegal short settings clamped to 4
  function automatic logic [BITS_W-1:0] char_bits(input logic [3:0] f);
    if (f < 4'd3) return BITS_W'(4);
    return BITS_W'(f) + BITS_W'(1);
  endfunction

  // half-bit ticks spanned by a field counted in whole bit times
  function automatic logic [CNT_W-1:0] bit_ticks(input logic [4:0] f);
    return {1'b0, f, 1'b0};
  endfunction

  // idle gap is field+1 bit times
  function automatic logic [CNT_W-1:0] gap_ticks(input logic [4:0] f);
    return (CNT_W'(f) + CNT_W'(1)) << 1;
  endfunction

  // place a right-justified character at the top of the shift word
  function automatic logic [DATA_W-1:0] align_msb(input logic [DATA_W-1:0] w,
                                                  input logic [BITS_W-1:0] n);
    return w << (BITS_W'(DATA_W) - n);
  endfunction
endpackage

// File: rtl/spicsm_clkdiv.sv
module spicsm_clkdiv #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam logic [DW-1:0] TOP = DW'(HALF_DIV - 1);

  logic [DW-1:0] cnt_q;
  logic          at_top;

  assign at_top = (cnt_q == TOP);
  assign tick_o = run_i && at_top;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (at_top)  cnt_q <= '0;
    else              cnt_q <= cnt_q + DW'(1);
  end
endmodule

// File: rtl/spicsm_shift.sv
module spicsm_shift
  import spicsm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_word_i,
  input  logic [BITS_W-1:0] load_bits_i,
  input  logic              lead_i,
  input  logic              trail_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_word_o
);
  logic [DATA_W-1:0] tx_q, rx_q;

  assign mosi_o    = tx_q[DATA_W-1];
  assign rx_word_o = rx_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= align_msb(load_word_i, load_bits_i);
      rx_q <= '0;
    end else begin
      if (trail_i) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
      if (lead_i)  rx_q <= {rx_q[DATA_W-2:0], miso_i};
    end
  end
endmodule

// File: rtl/spicsm_seq.sv
module spicsm_seq
  import spicsm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  lead_ticks_i,
  input  logic [CNT_W-1:0]  trail_ticks_i,
  input  logic [CNT_W-1:0]  gap_ticks_i,
  input  logic [BITS_W-1:0] nbits_i,
  output seq_state_e        state_o,
  output logic              phase_o,
  output logic              launch_o,
  output logic              use_pend_o,
  output logic              hold_o,
  output logic              lead_edge_o,
  output logic              trail_edge_o,
  output logic              last_edge_o
);
  seq_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BITS_W-1:0] bit_q;
  logic              phase_q, pend_q, gap_end, cnt_last;

  assign cnt_last     = (cnt_q == CNT_W'(1));
  assign gap_end      = (state_q == ST_GAP) && tick_i && cnt_last;
  assign lead_edge_o  = (state_q == ST_XFER) && tick_i && !phase_q;
  assign trail_edge_o = (state_q == ST_XFER) && tick_i && phase_q;
  assign last_edge_o  = trail_edge_o && (bit_q == nbits_i - BITS_W'(1));
  assign hold_o       = start_i && (state_q != ST_IDLE) && !pend_q;
  assign launch_o     = ((state_q == ST_IDLE) && (start_i || pend_q)) ||
                        (gap_end && pend_q);
  assign use_pend_o   = pend_q;
  assign state_o      = state_q;
  assign phase_o      = phase_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      phase_q <= 1'b0;
    end else if (launch_o) begin
      phase_q <= 1'b0;
      bit_q   <= '0;
      if (lead_ticks_i != '0) begin
        state_q <= ST_LEAD;
        cnt_q   <= lead_ticks_i;
      end else begin
        state_q <= ST_XFER;
      end
    end else if (tick_i) begin
      case (state_q)
        ST_LEAD: begin
          if (cnt_last) state_q <= ST_XFER;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        ST_XFER: begin
          if (!phase_q) begin
            phase_q <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            if (last_edge_o) begin
              if (trail_ticks_i != '0) begin
                state_q <= ST_TRAIL;
                cnt_q   <= trail_ticks_i;
              end else begin
                state_q <= ST_GAP;
                cnt_q   <= gap_ticks_i;
              end
            end else begin
              bit_q <= bit_q + BITS_W'(1);
            end
          end
        end
        ST_TRAIL: begin
          if (cnt_last) begin
            state_q <= ST_GAP;
            cnt_q   <= gap_ticks_i;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (cnt_last) state_q <= ST_IDLE;
          else          cnt_q   <= cnt_q - CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (launch_o) pend_q <= 1'b0;
    else if (hold_o)   pend_q <= 1'b1;
  end
endmodule

// File: rtl/spicsm_master.sv
module spicsm_master
  import spicsm_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_o
);
  spi_cfg_t          cfg_q;
  seq_state_e        state;
  logic              tick, phase, launch, use_pend, hold;
  logic              lead_edge, trail_edge, last_edge;
  logic              busy, cs_on, clk_active;
  logic [DATA_W-1:0] pend_tx_q, load_word, rx_word, rx_q;
  logic              done_q;
  logic [BITS_W-1:0] nbits;

  assign nbits      = char_bits(cfg_q.len);
  assign busy       = (state != ST_IDLE);
  assign cs_on      = (state == ST_LEAD) || (state == ST_XFER) || (state == ST_TRAIL);
  assign clk_active = (state == ST_XFER) && phase;
  assign load_word  = use_pend ? pend_tx_q : tx_data_i;

  spicsm_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (busy), .tick_o (tick)
  );

  spicsm_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .start_i       (start_i),
    .lead_ticks_i  (bit_ticks({1'b0, cfg_q.lead})),
    .trail_ticks_i (bit_ticks({1'b0, cfg_q.trail})),
    .gap_ticks_i   (gap_ticks(cfg_q.gap)),
    .nbits_i       (nbits),
    .state_o       (state),
    .phase_o       (phase),
    .launch_o      (launch),
    .use_pend_o    (use_pend),
    .hold_o        (hold),
    .lead_edge_o   (lead_edge),
    .trail_edge_o  (trail_edge),
    .last_edge_o   (last_edge)
  );

  spicsm_shift u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (launch),
    .load_word_i (load_word),
    .load_bits_i (nbits),
    .lead_i      (lead_edge),
    .trail_i     (trail_edge),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_word_o   (rx_word)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                cfg_q <= CFG_RESET;
    else if (cfg_we_i && !busy) cfg_q <= spi_cfg_t'(cfg_wdata_i);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   pend_tx_q <= '0;
    else if (hold) pend_tx_q <= tx_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      done_q <= last_edge;
      if (last_edge) rx_q <= rx_word;
    end
  end

  assign busy_o    = busy;
  assign done_o    = done_q;
  assign rx_data_o = rx_q;
  assign sclk_o    = cfg_q.clk_inv ^ clk_active;
  assign cs_o      = cfg_q.cs_low ^ cs_on;
endmodule

// File: rtl/spicsm_checker.sv
module spicsm_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tick,
  input logic busy,
  input logic cs_on,
  input logic cs_low,
  input logic clk_inv,
  input logic lead_edge,
  input logic last_edge,
  input logic sclk_o,
  input logic mosi_o,
  input logic cs_o,
  input logic done_o
);
  AST_CS_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (cs_o == cs_low)); // R1
  AST_SCLK_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_on |-> (sclk_o == clk_inv)); // R2
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_on && sclk_o != clk_inv) |-> $stable(mosi_o)); // R4
  AST_SAMPLE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_edge |-> (cs_on && sclk_o == clk_inv)); // R4
  AST_SCLK_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && !$stable(sclk_o)) |-> $past(tick)); // R5
  AST_GAP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_on) |=> !cs_on); // R7
  AST_DONE_FOLLOWS_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_edge |=> done_o); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
endmodule

bind spicsm_master spicsm_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick      (tick),
  .busy      (busy),
  .cs_on     (cs_on),
  .cs_low    (cfg_q.cs_low),
  .clk_inv   (cfg_q.clk_inv),
  .lead_edge (lead_edge),
  .last_edge (last_edge),
  .sclk_o    (sclk_o),
  .mosi_o    (mosi_o),
  .cs_o      (cs_o),
  .done_o    (done_o)
);

// File: tb/spicsm_master_tb.sv
module spicsm_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0, start = 1'b0, miso = 1'b0;
  logic [18:0] cfg_wdata = '0;
  logic [15:0] tx_data = '0;
  logic        busy, done, sclk, mosi, cs;
  logic [15:0] rx_data;

  int n_chk = 0, n_bad = 0, cyc = 0;

  // bench view of the active configuration
  logic b_cs_low = 1'b1, b_cpol = 1'b0;
  int   b_nbits = 8;
  logic [15:0] slave_word = '0;

  // monitor results
  int t_cs_on, t_cs_off, t_first, t_last, t_done, gap_meas;
  int edges = 0, done_cnt = 0, s_idx = 0;
  bit have_off = 0;
  logic prev_cs = 1'b0, prev_sclk = 1'b0;
  logic [15:0] mosi_word = '0, last_rx = '0;

  spicsm_master #(.HALF_DIV(H)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .cfg_we_i (cfg_we), .cfg_wdata_i (cfg_wdata),
    .tx_data_i (tx_data), .start_i (start), .busy_o (busy), .done_o (done),
    .rx_data_o (rx_data), .sclk_o (sclk), .mosi_o (mosi), .miso_i (miso), .cs_o (cs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // slave model and timing monitor
  always @(negedge clk) begin
    logic cs_act;
    cs_act = (cs != b_cs_low);
    if (cs_act && !prev_cs) begin
      t_cs_on = cyc;
      if (have_off) gap_meas = cyc - t_cs_off;
      edges = 0; mosi_word = '0;
      s_idx = b_nbits - 1;
      miso <= slave_word[s_idx];
    end
    if (sclk != b_cpol && prev_sclk == b_cpol) begin
      if (edges == 0) t_first = cyc;
      edges++;
      mosi_word = {mosi_word[14:0], mosi};
    end
    if (sclk == b_cpol && prev_sclk != b_cpol) begin
      t_last = cyc;
      s_idx--;
      if (s_idx >= 0) miso <= slave_word[s_idx];
    end
    if (!cs_act && prev_cs) begin
      t_cs_off = cyc; have_off = 1;
    end
    if (done) begin
      t_done = cyc; done_cnt++; last_rx = rx_data;
    end
    prev_cs = cs_act; prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] mk_cfg(input logic csl, cpol, input logic [3:0] len,
                                         lead, trail, input logic [4:0] gap);
    return {gap, trail, lead, len, cpol, csl};
  endfunction

  function automatic int exp_bits(input logic [3:0] len);
    return (len < 3) ? 4 : int'(len) + 1;
  endfunction

  task automatic write_cfg(input logic [18:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    b_cs_low = w[0]; b_cpol = w[1]; b_nbits = exp_bits(w[5:2]);
  endtask

  task automatic pulse_start(input logic [15:0] tx);
    @(negedge clk); #1; start = 1'b1; tx_data = tx;
    @(negedge clk); #1; start = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk); #1; guard++;
    end
    @(negedge clk); #1;
  endtask

  function automatic logic [15:0] msk(input logic [15:0] v, input int n);
    return v & 16'((32'd1 << n) - 1);
  endfunction

  // one frame with full timing and data checks
  task automatic frame_test(input string tg, input logic csl, cpol,
                            input logic [3:0] len, lead, trail, input logic [4:0] gap,
                            input logic [15:0] tx, slv);
    int n, d0;
    write_cfg(mk_cfg(csl, cpol, len, lead, trail, gap));
    slave_word = slv; n = exp_bits(len); d0 = done_cnt;
    chk(cs == csl, {tg, " R1 idle cs level"}, cs, csl);
    chk(sclk == cpol, {tg, " R2 idle sclk level"}, sclk, cpol);
    pulse_start(tx);
    wait_idle();
    chk(edges == n, {tg, " R3 edge count"}, edges, n);
    chk(mosi_word == msk(tx, n), {tg, " R4 mosi msb first"}, mosi_word, msk(tx, n));
    chk(t_first - t_cs_on == (2*lead+1)*H, {tg, " R5 lead"}, t_first - t_cs_on, (2*lead+1)*H);
    chk(t_cs_off - t_last == 2*trail*H, {tg, " R6 trail"}, t_cs_off - t_last, 2*trail*H);
    chk(done_cnt == d0 + 1, {tg, " R8 one done"}, done_cnt - d0, 1);
    chk(t_done == t_last, {tg, " R8 done timing"}, t_done - t_last, 0);
    chk(last_rx == msk(slv, n), {tg, " R4 R8 rx data"}, last_rx, msk(slv, n));
    chk(cs == csl && sclk == cpol, {tg, " R1 R2 levels after frame"}, {cs, sclk}, {csl, cpol});
  endtask

  // R9 R7: second start during trail is held and follows the gap
  task automatic pending_test();
    int d0;
    write_cfg(mk_cfg(1'b1, 1'b0, 4'd7, 4'd1, 4'd2, 5'd3));
    slave_word = 16'h5A; d0 = done_cnt; have_off = 0;
    pulse_start(16'h81);
    while (done_cnt == d0) begin @(negedge clk); #1; end
    chk(busy == 1'b1, "R9 busy during trail", busy, 1);
    pulse_start(16'hC3);
    tx_data = 16'hFFFF;
    wait_idle();
    chk(done_cnt == d0 + 2, "R9 two frames", done_cnt - d0, 2);
    chk(gap_meas == (3+1)*2*H, "R7 gap length", gap_meas, (3+1)*2*H);
    chk(mosi_word == 16'hC3, "R9 held character", mosi_word, 16'hC3);
  endtask

  // R10: config write during a frame is ignored
  task automatic cfg_busy_test();
    write_cfg(mk_cfg(1'b1, 1'b0, 4'd7, 4'd0, 4'd0, 5'd0));
    slave_word = 16'h96;
    pulse_start(16'h3C);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = mk_cfg(1'b0, 1'b1, 4'd3, 4'd0, 4'd0, 5'd0);
    @(negedge clk); cfg_we = 1'b0;
    wait_idle();
    chk(cs == 1'b1 && sclk == 1'b0, "R10 levels unchanged", {cs, sclk}, 2'b10);
    pulse_start(16'hE7);
    wait_idle();
    chk(edges == 8, "R10 length unchanged", edges, 8);
    chk(mosi_word == 16'hE7, "R10 data", mosi_word, 16'hE7);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cs == 1'b1, "R1 R11 reset cs", cs, 1);
    chk(sclk == 1'b0, "R11 reset sclk", sclk, 0);
    chk(busy == 1'b0, "R11 reset busy", busy, 0);
    chk(done == 1'b0, "R11 reset done", done, 0);
    chk(rx_data == 16'h0, "R11 reset rx", rx_data, 0);
    slave_word = 16'h00B4;
    pulse_start(16'h00A5);
    wait_idle();
    chk(edges == 8, "R11 R3 default length", edges, 8);
    frame_test("basic", 1'b1, 1'b0, 4'd7, 4'd2, 4'd1, 5'd5, 16'h00A5, 16'h003C);
    frame_test("wide", 1'b0, 1'b1, 4'd15, 4'd0, 4'd0, 5'd0, 16'hBEEF, 16'h1234);
    frame_test("clamp", 1'b1, 1'b1, 4'd1, 4'd3, 4'd2, 5'd1, 16'hFFF9, 16'hFFF6);
    frame_test("min", 1'b0, 1'b0, 4'd3, 4'd1, 4'd3, 5'd31, 16'h000C, 16'h0003);
    frame_test("odd", 1'b1, 1'b0, 4'd10, 4'd15, 4'd15, 5'd2, 16'h0555, 16'h02AA);
    pending_test();
    cfg_busy_test();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule